// File: doc/BRIEF.md
# Mantissa-Exponent Token Bucket Policer

This block meters a stream of ingress packets against two token buckets: a committed bucket and a peak bucket. Each bucket has a capacity and a refill amount. Both are written as an 8-bit mantissa and a 5-bit exponent. A value (m, e) stands for (1 + m/256) · 2^e bytes. A free-running tick generator divides the clock down to a base time unit. A programmable power-of-two shift then stretches that unit to set the refill interval.

Each packet is presented as a length with a valid strobe. The block works out the token cost of the packet. The cost is either the byte length less a programmable offset, or zero in packet mode. A signed adjust term is added to it, and the result is floored at 1/256 token. The packet is coloured green when the committed bucket covers the cost, yellow when only the peak bucket covers it, and red when neither does. One cycle later the block reports the colour together with the 2-bit action code held for that colour. Software sets everything through a small write-only register port.

Top module: `mtb_policer`

## Requirements
- R1: A bucket's capacity is (256 + m) · 2^e in 1/256-byte units, where m is the mantissa and e the exponent of its burst register. The bucket level never rises above the capacity that was in force on the previous cycle. Lowering a capacity clips the level on the next cycle.
- R2: On every refill tick each bucket gains (256 + m) · 2^e units, taken from its rate register, with saturation at its capacity.
- R3: Refill ticks occur once every BASE_CYC · 2^shift clock cycles. shift is the 4-bit value at address 4, bits [3:0].
- R4: An exponent of 24 or more gives the value zero. A burst register with such an exponent disables its bucket and holds its level at zero. A rate register with such an exponent stops its refill. A rate exponent of 23 is treated as 22, because the largest usable rate exponent is 22.
- R5: Cost = max(byte_part + (a − 256) · 2^x, 1) in 1/256-byte units. byte_part is 256 · (length − offset) in byte mode and 0 in packet mode. a is the 9-bit adjust mantissa and x the 5-bit adjust exponent. The offset may exceed the length.
- R6: With packet mode set, adjust mantissa 384 and adjust exponent 1, every packet costs one token, whatever its length.
- R7: Green (code 0) deducts the cost from the committed bucket. Yellow (code 1) deducts it from the peak bucket. Red (code 2) deducts nothing. Code 3 is never produced. A disabled peak bucket therefore yields only green or red.
- R8: The result carries the 2-bit action held for its colour: bits [1:0] of address 7 for green, [3:2] for yellow and [5:4] for red. Code 00 means pass and 01 means drop. The other codes are passed through unchanged.
- R9: res_valid is high exactly on the cycle after each cycle with pkt_valid high, and at no other time.
- R10: After reset, all four rate and burst registers hold mantissa 0 and exponent 24, and shift is 0. The adjust settings are mantissa 256 and exponent 0 in byte mode, and the offset is 0. The actions are green 00, yellow 00 and red 01. res_valid is low. So a packet sent right after reset is red with action 01.
- R11: Register map. Address 0 holds the committed rate, 1 the committed burst, 2 the peak rate and 3 the peak burst; each of these uses [7:0] for the mantissa and [12:8] for the exponent. Address 4 holds the shift. Address 5 holds the adjust mantissa in [8:0], the adjust exponent in [20:16] and packet mode in [24]. Address 6 holds the offset. Address 7 holds the actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_len | input | LEN_W | Packet length in bytes |
| res_valid | output | 1 | Result valid |
| res_color | output | 2 | Colour: 0 green, 1 yellow, 2 red |
| res_action | output | 2 | Action code for that colour |

## Verification
The level of a bucket is only visible through colours, so exact levels are probed with a triple of packets: level+1, then level, then 1. Only the exact level gives red, green, red. Refill is measured over a window of exactly one tick period with a small rate. This separates a correct mantissa from an ignored one, and a correct shift from an ignored one (20 bytes against 80). Cost is exercised in four ways: with an offset, with a negative adjust that hits the 1/256 floor (256 green and then a red), in packet mode against 1500-byte packets, and with a large adjust that tells the clamped rate exponent 22 apart from 23. A two-bucket sequence drives every colour and a remapped action table.

// File: rtl/mtb_pkg.sv
package mtb_pkg;

  // Token counts in 1/256-byte units; must hold (256+255)<<23 plus one refill.
  localparam int POL_TOK_W = 34;

  typedef enum logic [1:0] {
    CLR_GREEN  = 2'd0,
    CLR_YELLOW = 2'd1,
    CLR_RED    = 2'd2
  } color_e;

  typedef struct packed {
    logic [4:0] ex;
    logic [7:0] man;
  } me_t;

  localparam me_t ME_OFF = '{ex: 5'd24, man: 8'd0};

  // (256 + man) << ex, zero for ex >= 24; rate values clamp ex 23 to 22.
  function automatic logic [POL_TOK_W-1:0] me_to_units(me_t v, logic rate_clamp);
    logic [4:0] e;
    if (v.ex >= 5'd24) return '0;
    e = (rate_clamp && v.ex == 5'd23) ? 5'd22 : v.ex;
    return {{(POL_TOK_W-9){1'b0}}, 1'b1, v.man} << e;
  endfunction

endpackage

// File: rtl/mtb_tick_gen.sv
module mtb_tick_gen #(
  parameter int BASE_CYC = 250,
  parameter int SHIFT_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int BASE_W = (BASE_CYC > 1) ? $clog2(BASE_CYC) : 1;
  localparam int UNIT_W = 1 << SHIFT_W;

  logic [BASE_W-1:0] base_cnt;
  logic [UNIT_W-1:0] unit_cnt;
  logic [UNIT_W-1:0] unit_lim;
  logic              base_wrap;

  assign base_wrap = (base_cnt == BASE_W'(BASE_CYC - 1));
  assign unit_lim  = (UNIT_W'(1) << shift) - UNIT_W'(1);
  assign tick      = base_wrap && (unit_cnt >= unit_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_cnt <= '0;
      unit_cnt <= '0;
    end else begin
      base_cnt <= base_wrap ? '0 : base_cnt + BASE_W'(1);
      if (base_wrap) unit_cnt <= tick ? '0 : unit_cnt + UNIT_W'(1);
    end
  end
endmodule

// File: rtl/mtb_cost_calc.sv
module mtb_cost_calc #(
  parameter int LEN_W  = 16,
  parameter int OFS_W  = 16,
  parameter int COST_W = 48
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [OFS_W-1:0]  offset,
  input  logic [8:0]        adj_man,
  input  logic [4:0]        adj_exp,
  input  logic              pkt_mode,
  output logic [COST_W-1:0] cost
);
  logic signed [COST_W-1:0] len_s, ofs_s, byte_part, adj_base, adj_part, total;

  always_comb begin
    len_s     = signed'(COST_W'(len));
    ofs_s     = signed'(COST_W'(offset));
    byte_part = pkt_mode ? '0 : ((len_s - ofs_s) <<< 8);
    adj_base  = signed'(COST_W'(adj_man)) - signed'(COST_W'(256));
    adj_part  = adj_base <<< adj_exp;
    total     = byte_part + adj_part;
    cost      = (total < signed'(COST_W'(1))) ? COST_W'(1) : unsigned'(total);
  end
endmodule

// File: rtl/mtb_bucket.sv
module mtb_bucket #(
  parameter int TOK_W = 34
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOK_W-1:0] cap,
  input  logic [TOK_W-1:0] add,
  input  logic             take,
  input  logic [TOK_W-1:0] sub,
  output logic [TOK_W-1:0] level
);
  logic [TOK_W:0] sum;

  // take is only raised when sub <= level, so no underflow.
  assign sum = {1'b0, level} - (take ? {1'b0, sub} : '0) + {1'b0, add};

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else     level <= (sum > {1'b0, cap}) ? cap : sum[TOK_W-1:0];
  end
endmodule

// File: rtl/mtb_policer.sv
module mtb_policer
  import mtb_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int OFS_W    = 16,
  parameter int BASE_CYC = 250,
  parameter int SHIFT_W  = 4,
  parameter int COST_W   = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             res_valid,
  output logic [1:0]       res_color,
  output logic [1:0]       res_action
);
  localparam int TOK_W = POL_TOK_W;
  localparam int NB    = 2;   // 0: committed, 1: peak

  me_t                rate_q  [NB];
  me_t                burst_q [NB];
  logic [SHIFT_W-1:0] shift_q;
  logic [8:0]         adj_man_q;
  logic [4:0]         adj_exp_q;
  logic               mode_q;
  logic [OFS_W-1:0]   ofs_q;
  logic [1:0]         act_q [3];

  logic               unused_bits;
  assign unused_bits = ^{cfg_wdata[31:25], cfg_wdata[23:21]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NB; b++) begin
        rate_q[b]  <= ME_OFF;
        burst_q[b] <= ME_OFF;
      end
      shift_q   <= '0;
      adj_man_q <= 9'd256;
      adj_exp_q <= '0;
      mode_q    <= 1'b0;
      ofs_q     <= '0;
      act_q[0]  <= 2'b00;
      act_q[1]  <= 2'b00;
      act_q[2]  <= 2'b01;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: rate_q[0]  <= cfg_wdata[12:0];
        3'd1: burst_q[0] <= cfg_wdata[12:0];
        3'd2: rate_q[1]  <= cfg_wdata[12:0];
        3'd3: burst_q[1] <= cfg_wdata[12:0];
        3'd4: shift_q    <= cfg_wdata[SHIFT_W-1:0];
        3'd5: begin
          adj_man_q <= cfg_wdata[8:0];
          adj_exp_q <= cfg_wdata[20:16];
          mode_q    <= cfg_wdata[24];
        end
        3'd6: ofs_q <= cfg_wdata[OFS_W-1:0];
        default: begin
          act_q[0] <= cfg_wdata[1:0];
          act_q[1] <= cfg_wdata[3:2];
          act_q[2] <= cfg_wdata[5:4];
        end
      endcase
    end
  end

  logic tick;
  mtb_tick_gen #(.BASE_CYC(BASE_CYC), .SHIFT_W(SHIFT_W)) u_tick (
    .clk(clk), .rst(rst), .shift(shift_q), .tick(tick)
  );

  logic [COST_W-1:0] cost;
  mtb_cost_calc #(.LEN_W(LEN_W), .OFS_W(OFS_W), .COST_W(COST_W)) u_cost (
    .len(pkt_len), .offset(ofs_q), .adj_man(adj_man_q), .adj_exp(adj_exp_q),
    .pkt_mode(mode_q), .cost(cost)
  );

  logic [TOK_W-1:0] lvl   [NB];
  logic [TOK_W-1:0] cap_u [NB];
  logic [TOK_W-1:0] add_u [NB];
  logic             take  [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    assign cap_u[b] = me_to_units(burst_q[b], 1'b0);
    assign add_u[b] = tick ? me_to_units(rate_q[b], 1'b1) : '0;
    mtb_bucket #(.TOK_W(TOK_W)) u_bkt (
      .clk(clk), .rst(rst), .cap(cap_u[b]), .add(add_u[b]),
      .take(take[b]), .sub(cost[TOK_W-1:0]), .level(lvl[b])
    );
  end

  logic [TOK_W-1:0] lvl_cm, lvl_pk, cap_cm, cap_pk;
  logic             c_ok, p_ok;
  color_e           col_c;

  assign lvl_cm = lvl[0];
  assign lvl_pk = lvl[1];
  assign cap_cm = cap_u[0];
  assign cap_pk = cap_u[1];
  assign c_ok   = COST_W'(lvl_cm) >= cost;
  assign p_ok   = COST_W'(lvl_pk) >= cost;
  assign take[0] = pkt_valid && c_ok;
  assign take[1] = pkt_valid && !c_ok && p_ok;

  always_comb begin
    if (c_ok)      col_c = CLR_GREEN;
    else if (p_ok) col_c = CLR_YELLOW;
    else           col_c = CLR_RED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_color  <= 2'd0;
      res_action <= 2'd0;
    end else begin
      res_valid <= pkt_valid;
      if (pkt_valid) begin
        res_color  <= 2'(col_c);
        res_action <= act_q[col_c];
      end
    end
  end
endmodule

// File: rtl/mtb_policer_chk.sv
module mtb_policer_chk #(
  parameter int TOK_W = 34
) (
  input logic             clk,
  input logic             rst,
  input logic             pkt_valid,
  input logic             cfg_we,
  input logic             tick,
  input logic             c_ok,
  input logic             p_ok,
  input logic [TOK_W-1:0] lvl_cm,
  input logic [TOK_W-1:0] lvl_pk,
  input logic [TOK_W-1:0] cap_cm,
  input logic [TOK_W-1:0] cap_pk,
  input logic             res_valid,
  input logic [1:0]       res_color
);
  assert_result_follows_R9: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> res_valid);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |=> !res_valid);

  assert_color_legal_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_color != 2'b11));

  assert_cm_capped_R1: assert property (@(posedge clk) disable iff (rst)
    lvl_cm <= $past(cap_cm));

  assert_pk_capped_R1: assert property (@(posedge clk) disable iff (rst)
    lvl_pk <= $past(cap_pk));

  assert_red_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !c_ok && !p_ok && !cfg_we) |=>
      (lvl_cm >= $past(lvl_cm) && lvl_pk >= $past(lvl_pk)));

  assert_green_takes_R7: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && c_ok && !cfg_we && !tick) |=> (lvl_cm < $past(lvl_cm)));

  assert_disabled_empty_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(cap_pk) == '0) |-> (lvl_pk == '0));
endmodule

bind mtb_policer mtb_policer_chk #(.TOK_W(TOK_W)) u_chk (
  .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .cfg_we(cfg_we), .tick(tick),
  .c_ok(c_ok), .p_ok(p_ok), .lvl_cm(lvl_cm), .lvl_pk(lvl_pk),
  .cap_cm(cap_cm), .cap_pk(cap_pk), .res_valid(res_valid), .res_color(res_color)
);

// File: tb/mtb_policer_tb_top.sv
module mtb_policer_tb_top;
  localparam int LEN_W = 16;
  localparam int BASE  = 4;
  localparam logic [1:0] G = 2'd0, Y = 2'd1, RD = 2'd2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_addr = '0;
  logic [31:0]      cfg_wdata = '0;
  logic             pkt_valid = 1'b0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic             res_valid;
  logic [1:0]       res_color, res_action;

  mtb_policer #(.LEN_W(LEN_W), .BASE_CYC(BASE)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .res_valid(res_valid), .res_color(res_color), .res_action(res_action)
  );

  typedef struct {
    logic [1:0] col;
    logic [1:0] act;
    int         due;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0, pcount = 0;
  logic [1:0] a_g = 2'b00, a_y = 2'b00, a_r = 2'b01;

  always @(posedge clk) pcount <= pcount + 1;

  // Monitor: pop one expected item per result.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      exp_t e;
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected result color=%0d, expected none", res_color);
      end else begin
        e = sb.pop_front();
        if (res_color !== e.col || res_action !== e.act || pcount != e.due) begin
          n_bad++;
          $display("FAIL %s color=%0d act=%0d cyc=%0d expected color=%0d act=%0d cyc=%0d",
                   e.tag, res_color, res_action, pcount, e.col, e.act, e.due);
        end
      end
    end
  end

  function automatic logic [31:0] me(int m, int e);
    return 32'((e << 8) | m);
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int len, input logic [1:0] col, input string tag);
    exp_t e;
    @(negedge clk);
    pkt_valid = 1'b1;
    pkt_len   = LEN_W'(len);
    e.col = col;
    e.act = (col == G) ? a_g : (col == Y) ? a_y : a_r;
    e.due = pcount + 1;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic settle();
    @(negedge clk);
    pkt_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R9 %0d results missing, expected 0", sb.size());
      sb.delete();
    end
  endtask

  // Big refill for a few ticks on the given rate registers, then stop it.
  task automatic fill(input bit cm, input bit pk);
    if (cm) cfg_write(3'd0, me(0, 12));
    if (pk) cfg_write(3'd2, me(0, 12));
    repeat (40) @(negedge clk);
    if (cm) cfg_write(3'd0, me(0, 24));
    if (pk) cfg_write(3'd2, me(0, 24));
  endtask

  // Rate active for exactly p clock edges: exactly one tick of period p.
  task automatic one_tick(input logic [2:0] ra, input int m, input int e, input int p);
    cfg_write(ra, me(m, e));
    repeat (p - 2) @(negedge clk);
    cfg_write(ra, me(0, 24));
  endtask

  // Committed level must be exactly lvl (peak bucket empty).
  task automatic probe(input int lvl, input string tag);
    send(lvl + 1, RD, tag);
    if (lvl > 0) send(lvl, G, tag);
    send(1, RD, tag);
    settle();
  endtask

  task automatic empty_cm(input int m, input int e);
    cfg_write(3'd1, me(0, 24));
    cfg_write(3'd1, me(m, e));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 res_valid=%0b expected 0", res_valid);
    end
    // R10 / R4: everything disabled after reset, packet is red with drop
    send(1, RD, "R10");
    settle();

    // R1: capacity 1024 bytes, saturates despite many ticks
    cfg_write(3'd1, me(0, 10));
    fill(1, 0);
    probe(1024, "R1");

    // R1: mantissa in capacity, (1+128/256)*256 = 384
    cfg_write(3'd1, me(128, 8));
    fill(1, 0);
    probe(384, "R1");

    // R4: burst exponent 24 disables bucket
    cfg_write(3'd1, me(0, 24));
    fill(1, 0);
    send(1, RD, "R4");
    settle();

    // R2: one tick of (1+64/256)*16 = 20 bytes
    cfg_write(3'd1, me(0, 12));
    one_tick(3'd0, 64, 4, BASE);
    probe(20, "R2");

    // R3: shift 2 -> period 16; one window gives 20, not 80
    cfg_write(3'd4, 32'd2);
    empty_cm(0, 12);
    one_tick(3'd0, 64, 4, BASE * 4);
    probe(20, "R3");
    cfg_write(3'd4, 32'd0);

    // R4: rate exponent 23 acts as 22 -> 2^22 bytes; adjust gives cost 2^22
    empty_cm(0, 23);
    one_tick(3'd0, 0, 23, BASE);
    cfg_write(3'd5, 32'(384 | (23 << 16)));
    send(0, G, "R4");
    send(0, RD, "R4");
    settle();
    cfg_write(3'd5, 32'd256);

    // R5: offset 10 bytes on a 64 byte bucket
    cfg_write(3'd1, me(0, 6));
    fill(1, 0);
    cfg_write(3'd6, 32'd10);
    send(30, G, "R5");
    send(55, RD, "R5");
    send(54, G, "R5");
    send(11, RD, "R5");
    settle();
    cfg_write(3'd6, 32'd0);

    // R5: floor 1/256 token; one-byte bucket takes 256 packets
    cfg_write(3'd1, me(0, 0));
    fill(1, 0);
    cfg_write(3'd5, 32'd0);
    send(0, G, "R5");
    for (int i = 0; i < 255; i++) send(1, G, "R5");
    send(1, RD, "R5");
    settle();

    // R6: packet mode, 4-token bucket, 1500 byte packets
    cfg_write(3'd1, me(0, 2));
    fill(1, 0);
    cfg_write(3'd5, 32'(384 | (1 << 16) | (1 << 24)));
    for (int i = 0; i < 4; i++) send(1500, G, "R6");
    send(1500, RD, "R6");
    settle();
    cfg_write(3'd5, 32'd256);

    // R7 / R11: committed 256, peak 512 via addresses 1 and 3
    cfg_write(3'd1, me(0, 8));
    cfg_write(3'd3, me(0, 9));
    fill(1, 1);
    send(300, Y, "R7");
    send(200, G, "R7");
    send(300, RD, "R7");
    send(212, Y, "R11");
    send(56, G, "R7");
    send(1, RD, "R7");
    settle();

    // R8: remapped action table
    cfg_write(3'd7, 32'h0E);
    a_g = 2'b10; a_y = 2'b11; a_r = 2'b00;
    fill(1, 1);
    send(100, G, "R8");
    send(300, Y, "R8");
    send(600, RD, "R8");
    settle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule